// File: doc/BRIEF.md
# Configurable-Latency Read-Only Array Bus Responder

This block answers read requests from a 16-bit processor bus on behalf of an on-chip read-only array. Each request carries a 3-bit function code, a transfer size and a byte address. The block answers only when the code names an address space that its space field permits. When it answers, it holds the bus for a programmable number of bus cycles per transfer, where one bus cycle is two clocks. It then pulses an acknowledge and returns the data. A long-word read becomes two back-to-back word transfers. A word or long-word request at an odd address is refused and raises an address-error pulse instead.

A small control register holds the space field, the wait field and a lock bit. The reset values of the space and wait fields are build-time parameters. Software may rewrite the register until the lock bit is set. After that the register is frozen until the next reset. Requests that the space field does not permit get no response at all, so another responder or a bus timeout can deal with them.

Top module: `rom_bus_responder`

## Requirements
- R1: After reset, `cfg_rdata` equals {1'b0, SPACE_RST, WAIT_RST}, and `ack`, `addr_err` and `data_oe` are low.
- R2: While the lock bit is clear, a clock with `cfg_wr` high loads `cfg_wdata` into the register. The bit positions are: bits [1:0] wait field, bits [3:2] space field, bit 4 lock. `cfg_rdata` shows the register in the same positions from the next clock on.
- R3: Once the lock bit reads 1, it stays 1 until reset, and every later `cfg_wr` leaves `cfg_rdata` unchanged.
- R4: Function codes are 1 user data, 2 user program, 5 supervisor data and 6 supervisor program; any other code is never permitted. Space field 00 permits all four codes, 01 permits codes 5 and 6, 10 permits codes 2 and 6, and 11 permits code 6 only. A request that is not permitted produces no `ack`, no `addr_err` and no `data_oe`.
- R5: The wait field sets the bus cycles per transfer N: code 00 gives 3, 01 gives 4, 10 gives 5 and 11 gives 2. `req` is sampled on the clock edge that accepts it; counting the following clock as clock 1, `ack` is high in clock 2N.
- R6: `ack` is high for exactly one clock per transfer. `data_oe` is high from clock 1 through the final `ack` clock and low otherwise. A `req` that arrives while a transfer is in progress is ignored.
- R7: Array word w holds (w*16'h9E37 + 16'h3C5A) mod 2^16. The word read uses index addr>>1. For a word read (`size`=01), `rdata` carries that word in the `ack` clock. For a byte read (`size`=00), an even address places the high byte of the word on `rdata[15:8]` and an odd address places the low byte on `rdata[7:0]`; the other lane is zero.
- R8: A long-word read (`size`=10) makes two transfers of 2N clocks each. The first `ack` is in clock 2N and returns word addr>>1. The second `ack` is in clock 4N and returns the next word.
- R9: A permitted word or long-word request with `addr[0]`=1 raises `addr_err` for one clock in clock 1, with no `ack` and no `data_oe`. A request with `size`=11 gets no response.
- R10: When a configuration write and an accepted request fall on the same clock edge, the request uses the configuration held before that write. The next request uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write value {lock, space[1:0], wait[1:0]} |
| cfg_rdata | output | 5 | Control register contents, same layout |
| req | input | 1 | Request strobe, sampled when idle |
| fc | input | 3 | Function code of the request |
| size | input | 2 | 00 byte, 01 word, 10 long word, 11 reserved |
| addr | input | ADDR_W | Byte address within the array |
| ack | output | 1 | One-clock transfer acknowledge |
| addr_err | output | 1 | One-clock misaligned-request indication |
| data_oe | output | 1 | High while the block drives read data |
| rdata | output | 16 | Read data, zero when not driving |

## Verification
The critical overlap is a control-register write in the same clock in which the block accepts a request. Both act on one edge: the write changes the wait field, and the acceptance samples that field to set the latency. The bench drives `cfg_wr` and `req` together from a wait code of 2 bus cycles to a code of 5. The first transfer must still acknowledge in clock 4, and the following request must acknowledge in clock 10. A second overlap, a request arriving during a transfer, is provoked mid-transfer and judged by the count of acknowledges in the window.

// File: rtl/rom_resp_pkg.sv
package rom_resp_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] space;
        logic [1:0] wt;
    } cfg_t;

    // clocks per transfer minus one: two clocks per bus cycle
    function automatic logic [CNT_W-1:0] wait_to_clocks_m1(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            2'b00:   r = 4'd5;
            2'b01:   r = 4'd7;
            2'b10:   r = 4'd9;
            default: r = 4'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rom_cfg_reg.sv
module rom_cfg_reg
    import rom_resp_pkg::*;
#(
    parameter logic [1:0] SPACE_RST = 2'b00,
    parameter logic [1:0] WAIT_RST  = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [4:0] wdata,
    output cfg_t       cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr && !cfg_q.lock) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{lock: 1'b0, space: SPACE_RST, wt: WAIT_RST};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/rom_access_qual.sv
module rom_access_qual (
    input  logic [2:0] fc,
    input  logic [1:0] space,
    output logic       permitted
);
    logic is_super, is_prog, is_data;

    always_comb begin
        is_super = fc[2];
        is_prog  = (fc[1:0] == 2'b10);
        is_data  = (fc[1:0] == 2'b01);
        case (space)
            2'b00:   permitted = is_prog | is_data;
            2'b01:   permitted = (is_prog | is_data) & is_super;
            2'b10:   permitted = is_prog;
            default: permitted = is_prog & is_super;
        endcase
    end
endmodule

// File: rtl/rom_word_array.sv
module rom_word_array #(
    parameter int          WADDR_W = 11,
    parameter logic [15:0] MULT    = 16'h9E37,
    parameter logic [15:0] SEED    = 16'h3C5A
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic [15:0]        word
);
    logic [31:0] prod;

    always_comb begin
        prod = 32'(waddr) * 32'(MULT) + 32'(SEED);
        word = prod[15:0];
    end
endmodule

// File: rtl/rom_xfer_seq.sv
module rom_xfer_seq
    import rom_resp_pkg::*;
#(
    parameter int WADDR_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_err,
    input  logic               is_long,
    input  logic               is_byte,
    input  logic               byte_lo,
    input  logic [WADDR_W-1:0] waddr_in,
    input  logic [CNT_W-1:0]   cnt_init,
    output logic               busy,
    output logic               ack,
    output logic               addr_err,
    output logic [WADDR_W-1:0] cur_waddr,
    output logic               lane_byte,
    output logic               lane_lo
);
    typedef struct packed {
        logic               busy;
        logic               second;
        logic               is_long;
        logic               is_byte;
        logic               byte_lo;
        logic               err;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   reload;
        logic [WADDR_W-1:0] waddr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.second  = 1'b0;
                s_d.is_long = is_long;
                s_d.is_byte = is_byte;
                s_d.byte_lo = byte_lo;
                s_d.cnt     = cnt_init;
                s_d.reload  = cnt_init;
                s_d.waddr   = waddr_in;
            end else if (start_err) begin
                s_d.err = 1'b1;
            end
        end else if (s_q.cnt == '0) begin
            if (s_q.is_long && !s_q.second) begin
                s_d.second = 1'b1;
                s_d.cnt    = s_q.reload;
                s_d.waddr  = s_q.waddr + 1'b1;
            end else begin
                s_d.busy = 1'b0;
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign ack       = s_q.busy && (s_q.cnt == '0);
    assign addr_err  = s_q.err;
    assign cur_waddr = s_q.waddr;
    assign lane_byte = s_q.is_byte;
    assign lane_lo   = s_q.byte_lo;
endmodule

// File: rtl/rom_bus_responder.sv
module rom_bus_responder
    import rom_resp_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [1:0]  SPACE_RST = 2'b00,
    parameter logic [1:0]  WAIT_RST  = 2'b00,
    parameter logic [15:0] ROM_MULT  = 16'h9E37,
    parameter logic [15:0] ROM_SEED  = 16'h3C5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [4:0]        cfg_wdata,
    output logic [4:0]        cfg_rdata,
    input  logic              req,
    input  logic [2:0]        fc,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              ack,
    output logic              addr_err,
    output logic              data_oe,
    output logic [15:0]       rdata
);
    localparam int WADDR_W = ADDR_W - 1;

    cfg_t               cfg;
    logic               permitted, busy, aligned, take, start, start_err;
    logic               lane_byte, lane_lo;
    logic [WADDR_W-1:0] cur_waddr;
    logic [15:0]        word;
    xfer_size_e         sz;

    rom_cfg_reg #(.SPACE_RST(SPACE_RST), .WAIT_RST(WAIT_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .cfg(cfg)
    );

    rom_access_qual u_qual (.fc(fc), .space(cfg.space), .permitted(permitted));

    always_comb begin
        sz        = xfer_size_e'(size);
        aligned   = (sz == SZ_BYTE) || !addr[0];
        take      = req && !busy && permitted && (sz != SZ_RSVD);
        start     = take && aligned;
        start_err = take && !aligned;
    end

    rom_xfer_seq #(.WADDR_W(WADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_err(start_err),
        .is_long(sz == SZ_LONG), .is_byte(sz == SZ_BYTE), .byte_lo(addr[0]),
        .waddr_in(addr[ADDR_W-1:1]), .cnt_init(wait_to_clocks_m1(cfg.wt)),
        .busy(busy), .ack(ack), .addr_err(addr_err),
        .cur_waddr(cur_waddr), .lane_byte(lane_byte), .lane_lo(lane_lo)
    );

    rom_word_array #(.WADDR_W(WADDR_W), .MULT(ROM_MULT), .SEED(ROM_SEED)) u_rom (
        .waddr(cur_waddr), .word(word)
    );

    always_comb begin
        rdata = 16'h0000;
        if (busy) begin
            if (!lane_byte)   rdata = word;
            else if (lane_lo) rdata = {8'h00, word[7:0]};
            else              rdata = {word[15:8], 8'h00};
        end
    end

    assign data_oe   = busy;
    assign cfg_rdata = cfg;
endmodule

// File: rtl/rom_bus_responder_chk.sv
module rom_bus_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] cfg_rdata,
    input logic       ack,
    input logic       addr_err,
    input logic       data_oe
);
    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_with_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> data_oe);

    assert_err_excludes_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && addr_err));

    assert_err_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !data_oe);

    assert_lock_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4] |=> ($stable(cfg_rdata) && cfg_rdata[4]));
endmodule

bind rom_bus_responder rom_bus_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
    .ack(ack), .addr_err(addr_err), .data_oe(data_oe)
);

// File: tb/rom_bus_responder_test.sv
module rom_bus_responder_test;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [4:0]    cfg_wdata = '0;
    logic [4:0]    cfg_rdata;
    logic          req = 1'b0;
    logic [2:0]    fc = '0;
    logic [1:0]    size = '0;
    logic [AW-1:0] addr = '0;
    logic          ack, addr_err, data_oe;
    logic [15:0]   rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rom_bus_responder #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .fc(fc), .size(size), .addr(addr),
        .ack(ack), .addr_err(addr_err), .data_oe(data_oe), .rdata(rdata)
    );

    function automatic logic [15:0] rom_word(input logic [AW-2:0] w);
        logic [31:0] t;
        t = 32'(w) * 32'h9E37 + 32'h3C5A;
        return t[15:0];
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] v, input logic [4:0] exp_rb, input string rq);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(cfg_rdata == exp_rb, rq, "cfg readback", cfg_rdata, exp_rb);
    endtask

    // kind: 0 no response, 1 normal transfer, 2 address error
    task automatic run_req(input logic [2:0] f, input logic [1:0] sz, input logic [AW-1:0] a,
                           input int n, input int kind, input bit dup,
                           input bit wr_same, input logic [4:0] wv, input string rq);
        int nack = 0, a1 = -1, a2 = -1, nerr = 0, errclk = -1, badoe = 0;
        logic [15:0] d1 = '0, d2 = '0, e1, e2;
        int last, win;
        last = (kind == 1) ? ((sz == 2'b10) ? 4*n : 2*n) : 0;
        win  = 6*n + 6;
        fc = f; size = sz; addr = a; req = 1'b1;
        if (wr_same) begin cfg_wr = 1'b1; cfg_wdata = wv; end
        @(negedge clk);
        req = 1'b0; cfg_wr = 1'b0;
        for (int k = 1; k <= win; k++) begin
            if (ack) begin
                nack++;
                if (a1 < 0) begin a1 = k; d1 = rdata; end
                else if (a2 < 0) begin a2 = k; d2 = rdata; end
            end
            if (addr_err) begin nerr++; errclk = k; end
            if (data_oe != (k <= last)) badoe++;
            req = (dup && k == 2);
            @(negedge clk);
        end
        req = 1'b0;
        if (kind == 1) begin
            e1 = rom_word(a[AW-1:1]);
            e2 = rom_word(a[AW-1:1] + 1'b1);
            if (sz == 2'b00) e1 = a[0] ? {8'h00, e1[7:0]} : {e1[15:8], 8'h00};
            check(a1 == 2*n, rq, "first ack clock", a1, 2*n);
            check(d1 == e1, rq, "first data", d1, e1);
            if (sz == 2'b10) begin
                check(a2 == 4*n, rq, "second ack clock", a2, 4*n);
                check(d2 == e2, rq, "second data", d2, e2);
                check(nack == 2, rq, "ack count", nack, 2);
            end else begin
                check(nack == 1, rq, "ack count", nack, 1);
            end
            check(nerr == 0, rq, "addr_err count", nerr, 0);
        end else if (kind == 2) begin
            check(nerr == 1 && errclk == 1, rq, "addr_err clock", errclk, 1);
            check(nack == 0, rq, "ack count", nack, 0);
        end else begin
            check(nack == 0 && nerr == 0, rq, "response count", nack + nerr, 0);
        end
        check(badoe == 0, rq, "data_oe clocks wrong", badoe, 0);
    endtask

    task automatic t_reset;
        check(cfg_rdata == 5'b00000, "R1", "cfg after reset", cfg_rdata, 0);
        check(!ack && !addr_err && !data_oe, "R1", "outputs after reset",
              {ack, addr_err, data_oe}, 0);
    endtask

    task automatic t_basic;
        run_req(3'd2, 2'b01, 12'h010, 3, 1, 0, 0, '0, "R7");
        run_req(3'd1, 2'b00, 12'h124, 3, 1, 0, 0, '0, "R7");
        run_req(3'd5, 2'b00, 12'h125, 3, 1, 0, 0, '0, "R7");
        run_req(3'd6, 2'b01, 12'hFFE, 3, 1, 0, 0, '0, "R7");
    endtask

    task automatic t_wait;
        cfg_write(5'b00011, 5'b00011, "R2");
        run_req(3'd2, 2'b01, 12'h040, 2, 1, 0, 0, '0, "R5");
        cfg_write(5'b00001, 5'b00001, "R2");
        run_req(3'd2, 2'b01, 12'h042, 4, 1, 0, 0, '0, "R5");
        cfg_write(5'b00010, 5'b00010, "R2");
        run_req(3'd1, 2'b01, 12'h044, 5, 1, 0, 0, '0, "R5");
    endtask

    task automatic t_long;
        cfg_write(5'b00011, 5'b00011, "R2");
        run_req(3'd6, 2'b10, 12'h200, 2, 1, 0, 0, '0, "R8");
        run_req(3'd1, 2'b10, 12'hFFE, 2, 1, 0, 0, '0, "R8");
        run_req(3'd2, 2'b01, 12'h300, 2, 1, 1, 0, '0, "R6");
    endtask

    task automatic t_misalign;
        run_req(3'd2, 2'b01, 12'h301, 2, 2, 0, 0, '0, "R9");
        run_req(3'd5, 2'b10, 12'h303, 2, 2, 0, 0, '0, "R9");
        run_req(3'd2, 2'b11, 12'h304, 2, 0, 0, 0, '0, "R9");
    endtask

    task automatic t_space;
        run_req(3'd0, 2'b01, 12'h010, 2, 0, 0, 0, '0, "R4");
        run_req(3'd7, 2'b01, 12'h010, 2, 0, 0, 0, '0, "R4");
        cfg_write(5'b00111, 5'b00111, "R2");
        run_req(3'd2, 2'b01, 12'h010, 2, 0, 0, 0, '0, "R4");
        run_req(3'd1, 2'b01, 12'h010, 2, 0, 0, 0, '0, "R4");
        run_req(3'd5, 2'b01, 12'h010, 2, 1, 0, 0, '0, "R4");
        cfg_write(5'b01011, 5'b01011, "R2");
        run_req(3'd5, 2'b01, 12'h012, 2, 0, 0, 0, '0, "R4");
        run_req(3'd2, 2'b01, 12'h012, 2, 1, 0, 0, '0, "R4");
        cfg_write(5'b01111, 5'b01111, "R2");
        run_req(3'd2, 2'b01, 12'h014, 2, 0, 0, 0, '0, "R4");
        run_req(3'd6, 2'b01, 12'h014, 2, 1, 0, 0, '0, "R4");
        run_req(3'd2, 2'b01, 12'h015, 2, 0, 0, 0, '0, "R4");
    endtask

    task automatic t_overlap;
        cfg_write(5'b00011, 5'b00011, "R2");
        run_req(3'd2, 2'b01, 12'h020, 2, 1, 0, 1, 5'b00010, "R10");
        check(cfg_rdata == 5'b00010, "R10", "cfg after overlap", cfg_rdata, 5'b00010);
        run_req(3'd2, 2'b01, 12'h022, 5, 1, 0, 0, '0, "R10");
    endtask

    task automatic t_lock;
        cfg_write(5'b10000, 5'b10000, "R3");
        cfg_write(5'b01011, 5'b10000, "R3");
        cfg_write(5'b00001, 5'b10000, "R3");
        run_req(3'd1, 2'b01, 12'h050, 3, 1, 0, 0, '0, "R3");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wait();
        t_long();
        t_misalign();
        t_space();
        t_overlap();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule